// File: doc/BRIEF.md
# Store-Load Overlap Detector

This block keeps a short record of the stores issued in the current dispatch group and, for any load presented on its query port, reports whether that load reads bytes that one of the recorded stores writes. Each store record is a base tag, a signed byte offset from that base, and a byte count. A load with the same base tag conflicts when its byte interval meets the interval of any recorded store, or when both start at the same offset. The result is combinational, so an issue stage can hold back or pad a load within the same cycle.

Records are gathered by a capture strobe and thrown away all at once by a group-clear strobe. A small controller tracks how full the group is. It has three states. GRP_EMPTY means no record is held. GRP_OPEN means some slots are in use and some are free. GRP_FULL means every slot is in use. Its transitions are:
- T_FIRST: GRP_EMPTY to GRP_OPEN on the first accepted store, or straight to GRP_FULL when there is a single slot.
- T_FILL: GRP_OPEN to GRP_FULL when the last free slot is written.
- T_CLEAR: any state to GRP_EMPTY on group clear.

In any state where none of these applies, the state holds. Alias analysis beyond equal base tags is not attempted.

Top module: `sld_overlap_top`

## Requirements
- R1: A store is captured at the rising clock edge on which `st_vld` and `st_size_known` are both 1, `grp_clr` is 0 and a slot is free. Loads see it from the following cycle; in the capture cycle itself it is not yet visible to the query.
- R2: A store presented with `st_size_known` = 0 is not recorded and never causes a conflict.
- R3: At most NUM_SLOTS (default 4) stores are recorded per group. Stores arriving while the group is full are dropped until the next clear.
- R4: `grp_clr` = 1 at a rising edge empties the group for the next cycle. It takes priority over a store presented in the same cycle, which is dropped.
- R5: A load whose base tag and offset both equal those of a recorded store conflicts, whatever the two sizes are.
- R6: With equal base tags and store offset below load offset, the load conflicts exactly when store offset plus store size is greater than load offset. The comparison is signed and free of wrap-around.
- R7: With equal base tags and store offset above load offset, the load conflicts exactly when load offset plus load size is greater than store offset. The comparison is signed and free of wrap-around.
- R8: A recorded store with a base tag different from the load's never causes a conflict.
- R9: `conflict` is 0 whenever `ld_vld` is 0, `ld_size_known` is 0, or no store is recorded.
- R10: After reset the group is empty and `conflict` is 0.
- R11: `conflict` is the OR over all recorded slots of their individual match results. Each occupied slot is checked and unoccupied slots are ignored, so a match in any slot raises it combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| grp_clr | input | 1 | Ends the dispatch group and drops all records |
| st_vld | input | 1 | A store is presented for capture |
| st_size_known | input | 1 | The presented store has a known byte count |
| st_base | input | TAG_W | Base tag of the store address |
| st_ofs | input | OFS_W | Signed byte offset of the store |
| st_size | input | SIZE_W | Byte count of the store |
| ld_vld | input | 1 | A load is presented for checking |
| ld_size_known | input | 1 | The presented load has a known byte count |
| ld_base | input | TAG_W | Base tag of the load address |
| ld_ofs | input | OFS_W | Signed byte offset of the load |
| ld_size | input | SIZE_W | Byte count of the load |
| conflict | output | 1 | Load overlaps a recorded store |

## Verification
The bench builds the block with TAG_W = 2, OFS_W = 6, SIZE_W = 3 and NUM_SLOTS = 4. These narrow widths put every store offset and size against every load offset and size within reach, including pairs at the extreme signed offsets, where a naive sum would wrap. The full four-slot depth is kept, so the bench can also cover a full group, the dropped fifth store, the clear that wins over a simultaneous store, and matches found in each slot position.

// File: rtl/sld_pkg.sv
`timescale 1ns/1ps
package sld_pkg;
    typedef enum logic [1:0] {
        GRP_EMPTY = 2'd0,
        GRP_OPEN  = 2'd1,
        GRP_FULL  = 2'd2
    } grp_state_e;
endpackage

// File: rtl/sld_entry_cmp.sv
`timescale 1ns/1ps
module sld_entry_cmp #(
    parameter int TAG_W  = 8,
    parameter int OFS_W  = 16,
    parameter int SIZE_W = 8
) (
    input  logic              ent_vld,
    input  logic [TAG_W-1:0]  ent_base,
    input  logic [OFS_W-1:0]  ent_ofs,
    input  logic [SIZE_W-1:0] ent_size,
    input  logic [TAG_W-1:0]  ld_base,
    input  logic [OFS_W-1:0]  ld_ofs,
    input  logic [SIZE_W-1:0] ld_size,
    output logic              hit
);
    // two guard bits keep offset + size free of wrap-around
    localparam int SUM_W = OFS_W + 2;

    logic signed [SUM_W-1:0] st_lo, st_hi, ld_lo, ld_hi;
    logic                    base_eq, same_ofs, st_below;

    always_comb begin
        st_lo    = {{2{ent_ofs[OFS_W-1]}}, ent_ofs};
        ld_lo    = {{2{ld_ofs[OFS_W-1]}}, ld_ofs};
        st_hi    = st_lo + $signed({{(SUM_W-SIZE_W){1'b0}}, ent_size});
        ld_hi    = ld_lo + $signed({{(SUM_W-SIZE_W){1'b0}}, ld_size});
        base_eq  = (ent_base == ld_base);
        same_ofs = (ent_ofs == ld_ofs);
        st_below = (st_lo < ld_lo);
        hit      = ent_vld && base_eq &&
                   (same_ofs || (st_below ? (st_hi > ld_lo) : (ld_hi > st_lo)));
    end
endmodule

// File: rtl/sld_store_table.sv
`timescale 1ns/1ps
module sld_store_table
    import sld_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int TAG_W     = 8,
    parameter int OFS_W     = 16,
    parameter int SIZE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grp_clr,
    input  logic              st_vld,
    input  logic              st_size_known,
    input  logic [TAG_W-1:0]  st_base,
    input  logic [OFS_W-1:0]  st_ofs,
    input  logic [SIZE_W-1:0] st_size,
    output logic              any_rec,
    output logic              ent_vld  [NUM_SLOTS],
    output logic [TAG_W-1:0]  ent_base [NUM_SLOTS],
    output logic [OFS_W-1:0]  ent_ofs  [NUM_SLOTS],
    output logic [SIZE_W-1:0] ent_size [NUM_SLOTS]
);
    localparam int CNT_W = $clog2(NUM_SLOTS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_SLOTS - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_SLOTS);

    grp_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt;
    logic             accept;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GRP_EMPTY;
        else        state <= state_nxt;
    end

    // transitions: T_FIRST, T_FILL, T_CLEAR
    always_comb begin
        state_nxt = state;
        unique case (state)
            GRP_EMPTY: begin
                if (!grp_clr && accept)
                    state_nxt = (NUM_SLOTS == 1) ? GRP_FULL : GRP_OPEN;
            end
            GRP_OPEN: begin
                if (grp_clr)
                    state_nxt = GRP_EMPTY;
                else if (accept && cnt == LAST_IDX)
                    state_nxt = GRP_FULL;
            end
            GRP_FULL: begin
                if (grp_clr) state_nxt = GRP_EMPTY;
            end
            default: state_nxt = GRP_EMPTY;
        endcase
    end

    // outputs of the controller
    always_comb begin
        any_rec = (state != GRP_EMPTY);
        accept  = st_vld && st_size_known && !grp_clr && (state != GRP_FULL);
    end

    // write pointer / fill count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (grp_clr) cnt <= '0;
        else if (accept)  cnt <= cnt + 1'b1;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_base[g] <= '0;
                ent_ofs[g]  <= '0;
                ent_size[g] <= '0;
            end else if (accept && cnt == CNT_W'(g)) begin
                ent_base[g] <= st_base;
                ent_ofs[g]  <= st_ofs;
                ent_size[g] <= st_size;
            end
        end
        assign ent_vld[g] = (cnt > CNT_W'(g));
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT); // R3
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GRP_FULL && !grp_clr) |=> $stable(cnt)); // R3
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        grp_clr |=> (cnt == '0 && state == GRP_EMPTY)); // R4
    AST_NOSIZE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vld && !st_size_known) |=> $stable(cnt) || cnt == '0); // R2
    AST_STATE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GRP_EMPTY) |-> (cnt == '0)); // R10
endmodule

// File: rtl/sld_overlap_top.sv
`timescale 1ns/1ps
module sld_overlap_top #(
    parameter int NUM_SLOTS = 4,
    parameter int TAG_W     = 8,
    parameter int OFS_W     = 16,
    parameter int SIZE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grp_clr,
    input  logic              st_vld,
    input  logic              st_size_known,
    input  logic [TAG_W-1:0]  st_base,
    input  logic [OFS_W-1:0]  st_ofs,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              ld_vld,
    input  logic              ld_size_known,
    input  logic [TAG_W-1:0]  ld_base,
    input  logic [OFS_W-1:0]  ld_ofs,
    input  logic [SIZE_W-1:0] ld_size,
    output logic              conflict
);
    logic              any_rec;
    logic              ent_vld  [NUM_SLOTS];
    logic [TAG_W-1:0]  ent_base [NUM_SLOTS];
    logic [OFS_W-1:0]  ent_ofs  [NUM_SLOTS];
    logic [SIZE_W-1:0] ent_size [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_hit;

    sld_store_table #(
        .NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W)
    ) table_i (
        .clk(clk), .rst_n(rst_n), .grp_clr(grp_clr),
        .st_vld(st_vld), .st_size_known(st_size_known),
        .st_base(st_base), .st_ofs(st_ofs), .st_size(st_size),
        .any_rec(any_rec), .ent_vld(ent_vld), .ent_base(ent_base),
        .ent_ofs(ent_ofs), .ent_size(ent_size)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        sld_entry_cmp #(
            .TAG_W(TAG_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W)
        ) cmp_i (
            .ent_vld(ent_vld[g]), .ent_base(ent_base[g]),
            .ent_ofs(ent_ofs[g]), .ent_size(ent_size[g]),
            .ld_base(ld_base), .ld_ofs(ld_ofs), .ld_size(ld_size),
            .hit(slot_hit[g])
        );
    end

    assign conflict = ld_vld && ld_size_known && any_rec && (|slot_hit);

    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        grp_clr |=> !conflict); // R4
    AST_EXACT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld && ld_size_known && ent_vld[0] && ent_base[0] == ld_base &&
         ent_ofs[0] == ld_ofs) |-> conflict); // R5
    AST_FOREIGN_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_vld[0] && ent_base[0] != ld_base) |-> !slot_hit[0]); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_vld || !ent_vld[0]) |-> !conflict); // R9
endmodule

// File: tb/sld_overlap_top_tb_top.sv
`timescale 1ns/1ps
module sld_overlap_top_tb_top;
    localparam int NS = 4, TW = 2, OW = 6, SW = 3;
    localparam int OMIN = -(1 << (OW - 1));
    localparam int OMAX = (1 << (OW - 1)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grp_clr = 1'b0, st_vld = 1'b0, st_size_known = 1'b0;
    logic [TW-1:0] st_base = '0, ld_base = '0;
    logic [OW-1:0] st_ofs = '0, ld_ofs = '0;
    logic [SW-1:0] st_size = '0, ld_size = '0;
    logic ld_vld = 1'b0, ld_size_known = 1'b0;
    logic conflict;

    int checks = 0, failures = 0;
    int m_cnt = 0;
    int m_tag [NS];
    int m_ofs [NS];
    int m_sz  [NS];

    always #5 clk = ~clk;

    sld_overlap_top #(.NUM_SLOTS(NS), .TAG_W(TW), .OFS_W(OW), .SIZE_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .grp_clr(grp_clr),
        .st_vld(st_vld), .st_size_known(st_size_known),
        .st_base(st_base), .st_ofs(st_ofs), .st_size(st_size),
        .ld_vld(ld_vld), .ld_size_known(ld_size_known),
        .ld_base(ld_base), .ld_ofs(ld_ofs), .ld_size(ld_size),
        .conflict(conflict)
    );

    function automatic bit pair_hit(int st, int so, int ss, int lt, int lo, int ls);
        if (st != lt) return 1'b0;
        if (so == lo) return 1'b1;
        if (so < lo) return (so + ss) > lo;
        return (lo + ls) > so;
    endfunction

    function automatic bit model_q(int lt, int lo, int ls, bit lv, bit lk);
        bit r = 1'b0;
        if (!lv || !lk) return 1'b0;
        for (int i = 0; i < m_cnt; i++)
            if (pair_hit(m_tag[i], m_ofs[i], m_sz[i], lt, lo, ls)) r = 1'b1;
        return r;
    endfunction

    task automatic check(string rq, bit got, bit exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: conflict=%0b expected %0b (ld ofs=%0d size=%0d)",
                     rq, got, exp, $signed(ld_ofs), ld_size);
        end
    endtask

    task automatic probe(string rq, int lt, int lo, int ls, bit lv, bit lk);
        ld_vld = lv; ld_size_known = lk;
        ld_base = TW'(lt); ld_ofs = OW'(lo); ld_size = SW'(ls);
        #0.5;
        check(rq, conflict, model_q(lt, lo, ls, lv, lk));
    endtask

    task automatic do_store(int t, int o, int s, bit k);
        @(negedge clk);
        st_vld = 1'b1; st_size_known = k;
        st_base = TW'(t); st_ofs = OW'(o); st_size = SW'(s);
        @(negedge clk);
        st_vld = 1'b0; st_size_known = 1'b0;
        if (k && m_cnt < NS) begin
            m_tag[m_cnt] = t; m_ofs[m_cnt] = o; m_sz[m_cnt] = s;
            m_cnt++;
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        grp_clr = 1'b1;
        @(negedge clk);
        grp_clr = 1'b0;
        m_cnt = 0;
    endtask

    task automatic run_all();
        // R10: reset state
        @(negedge clk);
        probe("R10", 0, 0, 1, 1, 1);
        rst_n = 1'b1;
        @(negedge clk);
        probe("R10", 0, 0, 7, 1, 1);

        // R1: not visible in capture cycle, visible afterwards
        @(negedge clk);
        st_vld = 1'b1; st_size_known = 1'b1; st_base = 2'd1; st_ofs = 6'd4; st_size = 3'd2;
        ld_vld = 1'b1; ld_size_known = 1'b1; ld_base = 2'd1; ld_ofs = 6'd4; ld_size = 3'd1;
        #0.5 check("R1", conflict, 1'b0);
        @(negedge clk);
        st_vld = 1'b0;
        m_tag[0] = 1; m_ofs[0] = 4; m_sz[0] = 2; m_cnt = 1;
        probe("R1", 1, 4, 1, 1, 1);

        // R9: invalid query or unknown load size
        probe("R9", 1, 4, 1, 0, 1);
        probe("R9", 1, 4, 1, 1, 0);
        probe("R9", 1, 4, 1, 0, 0);

        // R2: unknown-size store is not recorded
        do_clear();
        do_store(2, -5, 4, 0);
        probe("R2", 2, -5, 4, 1, 1);
        probe("R2", 2, -4, 1, 1, 1);

        // R3 / R11: fill all slots, hit each slot, drop fifth store
        do_clear();
        do_store(0, -30, 2, 1);
        do_store(1, -10, 3, 1);
        do_store(2, 10, 1, 1);
        do_store(3, 25, 5, 1);
        probe("R11", 0, -29, 1, 1, 1);
        probe("R11", 1, -8, 1, 1, 1);
        probe("R11", 2, 10, 0, 1, 1);
        probe("R11", 3, 29, 3, 1, 1);
        probe("R11", 0, -10, 1, 1, 1);
        do_store(0, 0, 7, 1);
        probe("R3", 0, 0, 7, 1, 1);
        probe("R3", 0, 3, 1, 1, 1);

        // R4: clear empties, and wins over a simultaneous store
        do_clear();
        probe("R4", 3, 29, 3, 1, 1);
        @(negedge clk);
        grp_clr = 1'b1; st_vld = 1'b1; st_size_known = 1'b1;
        st_base = 2'd1; st_ofs = 6'd9; st_size = 3'd3;
        @(negedge clk);
        grp_clr = 1'b0; st_vld = 1'b0; m_cnt = 0;
        probe("R4", 1, 9, 3, 1, 1);
        do_store(1, 9, 3, 1);
        probe("R4", 1, 10, 1, 1, 1);

        // R8: foreign tag never matches
        probe("R8", 2, 9, 3, 1, 1);

        // R5 / R6 / R7 / R8: exhaustive single-store sweep
        for (int so = OMIN; so <= OMAX; so++) begin
            for (int ss = 0; ss < (1 << SW); ss++) begin
                do_clear();
                do_store(1, so, ss, 1);
                for (int lo = OMIN; lo <= OMAX; lo++) begin
                    @(negedge clk);
                    for (int ls = 0; ls < (1 << SW); ls++) begin
                        if (so == lo)     probe("R5", 1, lo, ls, 1, 1);
                        else if (so < lo) probe("R6", 1, lo, ls, 1, 1);
                        else              probe("R7", 1, lo, ls, 1, 1);
                    end
                end
                probe("R8", 2, so, ss, 1, 1);
            end
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                #(200000 * 10);
                failures++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule